// File: doc/BRIEF.md
# AC-link Output Frame Receiver

This block sits on the codec side of a serial AC-link. It watches the frame marker line and the serial data line coming from the controller. Both lines change on the rising edge of the bit clock, so the block captures them on the falling edge. A low-to-high step of the marker, seen between two falling edges, starts a frame. The first frame bit is captured on the falling edge after that. The block then cuts the stream into one 16-bit tag slot and twelve 20-bit data slots. All slots arrive MSB first.

Each finished slot is shown on the slot word output with its slot number and a one-cycle strobe. A separate register block can then pick up command, data and sample slots without counting bits itself. The frame-valid bit and the twelve per-slot valid bits of the tag are held on their own outputs until the next tag arrives.

If the marker rises again before a frame is complete, the block drops the unfinished frame and locks to the new one. If a frame ends and no new marker follows, the block stays idle.

Top module: `acOutFrameRx`

## Requirements
- R1: All state changes on the falling edge of `bitClk`. A frame starts on the falling edge where `syncIn` is captured high after being captured low on the previous falling edge. Frame bit position 0 is captured on the next falling edge, and one bit is captured on each falling edge after that. A strobe caused by a bit driven in rising-edge period c can be seen in period c+1.
- R2: The tag slot is frame bit positions 0 to 15, MSB first. When it completes, `slotIdx` = 0, `slotData[15:0]` holds the tag and `slotData[19:16]` = 0.
- R3: Slot k (k = 1 to 12) is frame bit positions 16+20(k-1) to 35+20(k-1), MSB first. When it completes, `slotIdx` = k and `slotData` holds its 20 bits.
- R4: `slotStrobe` is high for one `bitClk` period, starting at the falling edge that captures the last bit of a slot. A complete frame gives exactly 13 strobes, with indices 0 to 12 in order.
- R5: When the tag completes, `frameValid` takes tag bit 15 and `slotValid[k-1]` takes tag bit 15-k (for k = 1 to 12). Both hold their values until the next tag completes.
- R6: If the marker rise falls on the same falling edge as frame bit 255, that bit still completes slot 12 and a new frame starts. Frames can therefore follow each other with no gap.
- R7: If the marker rises before bit 255 has been captured, the unfinished frame is dropped. No strobe is given on that edge, and none for the rest of the old frame. Decoding restarts at bit 0 of the new frame.
- R8: After bit 255 of a frame, if no new marker rise comes, the block ignores the data line and gives no strobes until the next rise.
- R9: While `rstN` is low, `slotStrobe`, `slotIdx`, `slotData`, `frameValid` and `slotValid` are all 0. A marker that is already high when reset is released does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock; inputs are captured on its falling edge |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | Frame marker from the controller |
| serialIn | input | 1 | Serial output data from the controller, MSB first |
| slotStrobe | output | 1 | One-cycle pulse when a slot word is complete |
| slotIdx | output | 4 | Number of the completed slot, 0 to 12 |
| slotData | output | 20 | Completed slot word (tag zero-extended for slot 0) |
| frameValid | output | 1 | Frame-valid bit of the most recent tag |
| slotValid | output | 12 | Slot-valid bits of the most recent tag; bit k-1 is for slot k |

## Verification
The assertions assume three things about the inputs:
- The marker and the data line change only away from the falling edge.
- The marker stays high for at least one falling edge once it rises.
- Any re-sync comes at least sixteen bits into a frame, so the marker has gone low before it rises again.

The bench drives both lines just after the rising edge and keeps the marker high for the tag period, as a controller would. It places every early re-sync at bit 16 or later. Frame contents come from an arithmetic pattern, so every tag-valid combination used and every slot boundary can be predicted in the bench.

// File: rtl/acOutRxPkg.sv
package acOutRxPkg;
  // Strobes from the bit-position control to the slot datapath.
  typedef struct packed {
    logic shiftEn;   // capture the current serial bit
    logic wordDone;  // the current bit closes a slot
    logic tagDone;   // the slot being closed is the tag slot
  } rxStrobeT;
endpackage

// File: rtl/acOutRxCtrl.sv
module acOutRxCtrl
  import acOutRxPkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12,
  localparam int IDX_W = $clog2(NUM_SLOTS + 1),
  localparam int CNT_W = $clog2(SLOT_BITS)
) (
  input  logic             bitClk,
  input  logic             rstN,
  input  logic             syncIn,
  output rxStrobeT         strobe,
  output logic [IDX_W-1:0] slotNum
);

  logic             syncPrev;
  logic             active;
  logic [IDX_W-1:0] slotCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             syncRise;
  logic             lastBit;
  logic             frameEnd;
  logic             take;

  assign syncRise = syncIn && !syncPrev;
  assign lastBit  = (slotCnt == '0) ? (bitCnt == CNT_W'(TAG_BITS - 1))
                                    : (bitCnt == CNT_W'(SLOT_BITS - 1));
  assign frameEnd = active && lastBit && (slotCnt == IDX_W'(NUM_SLOTS));
  // A marker rise cuts the frame short unless it lands on the final bit.
  assign take     = active && !(syncRise && !frameEnd);

  always_comb begin
    strobe.shiftEn  = take;
    strobe.wordDone = take && lastBit;
    strobe.tagDone  = take && lastBit && (slotCnt == '0);
  end
  assign slotNum = slotCnt;

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b1;
      active   <= 1'b0;
      slotCnt  <= '0;
      bitCnt   <= '0;
    end else begin
      syncPrev <= syncIn;
      if (syncRise) begin
        active  <= 1'b1;
        slotCnt <= '0;
        bitCnt  <= '0;
      end else if (take) begin
        if (lastBit) begin
          bitCnt <= '0;
          if (frameEnd) active <= 1'b0;
          else          slotCnt <= slotCnt + 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R1: a marker rise arms the counters at bit 0 of slot 0
  a_r1_rise_arms: assert property (@(negedge bitClk) disable iff (!rstN)
    syncRise |=> (active && slotCnt == '0 && bitCnt == '0));

  // R8: a frame that ends with no new marker leaves the receiver idle
  a_r8_idle_after_end: assert property (@(negedge bitClk) disable iff (!rstN)
    (frameEnd && !syncRise) |=> !active);

  // R3: bit and slot counters stay inside the frame layout
  a_r3_count_bounds: assert property (@(negedge bitClk) disable iff (!rstN)
    (bitCnt < CNT_W'(SLOT_BITS)) && (slotCnt <= IDX_W'(NUM_SLOTS)));

endmodule

// File: rtl/acOutRxData.sv
module acOutRxData
  import acOutRxPkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12,
  localparam int IDX_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 bitClk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  rxStrobeT             strobe,
  input  logic [IDX_W-1:0]     slotNum,
  output logic                 slotStrobe,
  output logic [IDX_W-1:0]     slotIdx,
  output logic [SLOT_BITS-1:0] slotData,
  output logic                 frameValid,
  output logic [NUM_SLOTS-1:0] slotValid
);

  logic [SLOT_BITS-2:0] shiftReg;
  logic [SLOT_BITS-1:0] fullWord;
  logic [SLOT_BITS-1:0] tagWord;

  assign fullWord = {shiftReg, serialIn};
  assign tagWord  = {{(SLOT_BITS - TAG_BITS){1'b0}}, fullWord[TAG_BITS-1:0]};

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      slotStrobe <= 1'b0;
      slotIdx    <= '0;
      slotData   <= '0;
      frameValid <= 1'b0;
    end else begin
      slotStrobe <= strobe.wordDone;
      if (strobe.shiftEn) shiftReg <= fullWord[SLOT_BITS-2:0];
      if (strobe.wordDone) begin
        slotIdx  <= slotNum;
        slotData <= (slotNum == '0) ? tagWord : fullWord;
      end
      if (strobe.tagDone) frameValid <= fullWord[TAG_BITS-1];
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gValid
    always_ff @(negedge bitClk or negedge rstN) begin
      if (!rstN)               slotValid[g] <= 1'b0;
      else if (strobe.tagDone) slotValid[g] <= fullWord[TAG_BITS-2-g];
    end
  end

  // R4: a slot strobe never lasts two cycles
  a_r4_strobe_pulse: assert property (@(negedge bitClk) disable iff (!rstN)
    slotStrobe |=> !slotStrobe);

  // R2: the tag word is zero-extended
  a_r2_tag_zero_ext: assert property (@(negedge bitClk) disable iff (!rstN)
    (slotStrobe && slotIdx == '0) |-> (slotData[SLOT_BITS-1:TAG_BITS] == '0));

  // R3: slot numbers stay within the frame
  a_r3_idx_range: assert property (@(negedge bitClk) disable iff (!rstN)
    slotStrobe |-> (slotIdx <= IDX_W'(NUM_SLOTS)));

  // R5: valid flags move only when a tag completes
  a_r5_valid_hold: assert property (@(negedge bitClk) disable iff (!rstN)
    !strobe.tagDone |=> ($stable(frameValid) && $stable(slotValid)));

endmodule

// File: rtl/acOutFrameRx.sv
module acOutFrameRx
  import acOutRxPkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12,
  localparam int IDX_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 bitClk,
  input  logic                 rstN,
  input  logic                 syncIn,
  input  logic                 serialIn,
  output logic                 slotStrobe,
  output logic [IDX_W-1:0]     slotIdx,
  output logic [SLOT_BITS-1:0] slotData,
  output logic                 frameValid,
  output logic [NUM_SLOTS-1:0] slotValid
);

  rxStrobeT         ctlStrobe;
  logic [IDX_W-1:0] ctlSlot;

  acOutRxCtrl #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) uCtrl (
    .bitClk (bitClk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .strobe (ctlStrobe),
    .slotNum(ctlSlot)
  );

  acOutRxData #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) uData (
    .bitClk    (bitClk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .strobe    (ctlStrobe),
    .slotNum   (ctlSlot),
    .slotStrobe(slotStrobe),
    .slotIdx   (slotIdx),
    .slotData  (slotData),
    .frameValid(frameValid),
    .slotValid (slotValid)
  );

endmodule

// File: tb/sim_acOutFrameRx.sv
module sim_acOutFrameRx;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_MAX    = 1024;

  logic        bitClk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncIn = 1'b0;
  logic        serialIn = 1'b0;
  logic        slotStrobe;
  logic [3:0]  slotIdx;
  logic [19:0] slotData;
  logic        frameValid;
  logic [11:0] slotValid;

  int errors = 0;
  int checks = 0;
  int g = 0;
  logic carry = 1'b0;

  logic [3:0]  logIdx[LOG_MAX];
  logic [19:0] logData[LOG_MAX];
  logic        logFv[LOG_MAX];
  logic [11:0] logSv[LOG_MAX];
  int          logCyc[LOG_MAX];
  int          nLog = 0;
  logic [3:0]  expIdx[LOG_MAX];
  logic [19:0] expData[LOG_MAX];
  logic        expFv[LOG_MAX];
  logic [11:0] expSv[LOG_MAX];
  int          expCyc[LOG_MAX];
  int          nExp = 0;

  acOutFrameRx u0 (
    .bitClk(bitClk), .rstN(rstN), .syncIn(syncIn), .serialIn(serialIn),
    .slotStrobe(slotStrobe), .slotIdx(slotIdx), .slotData(slotData),
    .frameValid(frameValid), .slotValid(slotValid)
  );

  always #(CLK_PERIOD / 2) bitClk = ~bitClk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] slotWord(int fid, int k);
    if (fid == 1) return 20'hFFFFF;
    if (fid == 2) return 20'h00000;
    return 20'((fid * 40503 + k * 7919 + 32'h2A5C3) ^ (k << (fid % 13)));
  endfunction

  function automatic logic [15:0] tagOf(int fid);
    if (fid == 1) return 16'hFFFF;
    if (fid == 2) return 16'h0000;
    return 16'((fid * 32'h9E37) ^ (fid << 5) ^ 32'hA5A5);
  endfunction

  function automatic logic frameBit(int fid, int pos);
    logic [15:0] t;
    logic [19:0] w;
    t = tagOf(fid);
    if (pos < 16) return t[15-pos];
    w = slotWord(fid, (pos - 16) / 20 + 1);
    return w[19 - (pos - 16) % 20];
  endfunction

  // One rising-edge period: log the design's outputs, then drive the lines.
  task automatic driveBit(logic s, logic d);
    @(posedge bitClk);
    if (slotStrobe === 1'b1 && nLog < LOG_MAX) begin
      logIdx[nLog]  = slotIdx;
      logData[nLog] = slotData;
      logFv[nLog]   = frameValid;
      logSv[nLog]   = slotValid;
      logCyc[nLog]  = g;
      nLog++;
    end
    syncIn   <= s;
    serialIn <= d;
    g++;
  endtask

  // Marker cycle plus frame bits 0..nb-1; bit 255 rides on the next marker.
  task automatic playFrame(int fid, int nb);
    int st;
    logic [15:0] t;
    st = g;
    t = tagOf(fid);
    driveBit(1'b1, carry);
    for (int p = 0; p < nb; p++) driveBit(p < 15, frameBit(fid, p));
    carry = (nb == 255) ? frameBit(fid, 255) : 1'b1;
    for (int k = 0; k <= 12; k++) begin
      int lastPos;
      lastPos = (k == 0) ? 15 : 15 + 20 * k;
      if ((nb == 255 || lastPos <= nb - 1) && nExp < LOG_MAX) begin
        expIdx[nExp]  = 4'(k);
        expData[nExp] = (k == 0) ? {4'h0, t} : slotWord(fid, k);
        expFv[nExp]   = t[15];
        for (int j = 0; j < 12; j++) expSv[nExp][j] = t[14-j];
        expCyc[nExp]  = st + 1 + lastPos + 1;
        nExp++;
      end
    end
  endtask

  task automatic tailIdle(int n);
    driveBit(1'b0, carry);
    for (int i = 0; i < n; i++) driveBit(1'b0, i[0] ^ i[2]);
    carry = 1'b0;
  endtask

  task automatic compareLog(string req);
    int n;
    check({req, " strobe count (R4)"}, nLog, nExp);
    n = (nLog < nExp) ? nLog : nExp;
    for (int i = 0; i < n; i++) begin
      check("R4 slot order", {28'h0, logIdx[i]}, {28'h0, expIdx[i]});
      check(expIdx[i] == 0 ? "R2 tag word" : "R3 slot word",
            {12'h0, logData[i]}, {12'h0, expData[i]});
      check("R5 frameValid", {31'h0, logFv[i]}, {31'h0, expFv[i]});
      check("R5 slotValid", {20'h0, logSv[i]}, {20'h0, expSv[i]});
      check("R1 strobe cycle", logCyc[i], expCyc[i]);
    end
    nLog = 0;
    nExp = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    syncIn = 1'b1;
    repeat (3) @(posedge bitClk);
    #1;
    check("R9 reset strobe", {31'h0, slotStrobe}, 32'h0);
    check("R9 reset data", {12'h0, slotData}, 32'h0);
    check("R9 reset idx", {28'h0, slotIdx}, 32'h0);
    check("R9 reset valid", {19'h0, frameValid, slotValid}, 32'h0);
    @(posedge bitClk);
    rstN <= 1'b1;
    // R9: marker already high at reset release starts nothing
    for (int i = 0; i < 6; i++) driveBit(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) driveBit(1'b0, 1'b0);
    compareLog("R9");
    check("R9 valid after idle", {19'h0, frameValid, slotValid}, 32'h0);

    // R6: back-to-back complete frames, including all-ones and all-zeros
    for (int f = 1; f <= 6; f++) playFrame(f, 255);
    tailIdle(40);
    compareLog("R6");

    // R8: a complete frame followed by a long stretch of noise, no marker
    playFrame(7, 255);
    tailIdle(300);
    compareLog("R8");

    // R7: early re-sync at several bit positions, each followed by a full frame
    begin
      int cuts[7] = '{16, 17, 35, 36, 100, 235, 254};
      for (int i = 0; i < 7; i++) begin
        playFrame(10 + i, cuts[i]);
        playFrame(20 + i, 255);
      end
    end
    tailIdle(5);
    compareLog("R7");

    // R5: sweep of tag patterns over consecutive frames
    for (int f = 30; f < 46; f++) playFrame(f, 255);
    tailIdle(5);
    compareLog("R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule